// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable flow-through SRAM with a built-in burst address generator. One of two start strobes loads an external word address into an address register and clears a 2-bit burst counter. After that, an advance input steps the counter. The counter supplies the two low address bits in either linear or interleaved order, chosen by a static order-select input. The read path has no output register. The word for the address in effect in a cycle is on `rdata_o` in that same cycle, so a four-word burst takes one load cycle followed by three advance cycles.

Writes happen at the clock edge that ends the cycle. Either all four byte lanes are written (global write) or only the lanes picked by the lane selects (byte write). Three chip selects qualify every start strobe. A burst that was started while the block was selected continues until another strobe arrives. The read-enable and sleep inputs act on the output combinationally. While sleep is high the block ignores all clocked commands and keeps the array contents.

Top module: `sburst_sram`

## Requirements
- R1: When the block is selected (`sel1_n_i`=0, `sel2_i`=1, `sel3_n_i`=0), either strobe `ld_cpu_i` or `ld_ctl_i` makes `addr_i` the address of that cycle, and a read returns the word at `addr_i` in that same cycle.
- R2: A strobe while the block is deselected loads no address and writes nothing. Until the next selected strobe, reads return zero.
- R3: With order-select `lin_i`=1, each advance cycle (`adv_i`=1, no strobe) sets the low two address bits to the start bits plus the count, modulo 4. The upper address bits are unchanged.
- R4: With `lin_i`=0, the low two address bits equal the start bits XOR the count.
- R5: With no strobe and no advance, the address holds and the same word is returned again.
- R6: `gwr_i`=1 in an active cycle writes all four lanes from `wdata_i`, whatever `bwe_i` and `lane_sel_i` are.
- R7: `bwe_i`=1 with `gwr_i`=0 writes only the lanes k with `lane_sel_i[k]`=1. Lane k is bits 8k+7 down to 8k.
- R8: `sleep_i`=1 forces `rdata_o` to zero without waiting for a clock, makes the block ignore strobes, advance and writes, and keeps the array contents. The held address is in use again as soon as sleep drops.
- R9: `rdata_o` carries the array word only when `rd_en_i`=1 and the cycle is not a write (`gwr_i`=0 and `bwe_i`=0). Otherwise it is zero.
- R10: After reset no burst is active, the counter is zero and `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W (8) | Word address loaded by a strobe |
| wdata_i | input | DATA_W (32) | Write data |
| sel1_n_i | input | 1 | Chip select, active low |
| sel2_i | input | 1 | Chip select, active high |
| sel3_n_i | input | 1 | Chip select, active low |
| ld_cpu_i | input | 1 | Burst start strobe, processor side |
| ld_ctl_i | input | 1 | Burst start strobe, controller side |
| adv_i | input | 1 | Step the burst counter |
| lin_i | input | 1 | Burst order: 1 linear, 0 interleaved (static) |
| bwe_i | input | 1 | Byte-write enable |
| lane_sel_i | input | LANES (4) | Per-lane write select |
| gwr_i | input | 1 | Global write, all lanes |
| rd_en_i | input | 1 | Output enable, combinational |
| sleep_i | input | 1 | Low-power request, combinational |
| rdata_o | output | DATA_W (32) | Flow-through read data |

## Verification
The read result is due in the cycle its address is presented, because no register lies between the address selection and `rdata_o`. The bench therefore drives each cycle's inputs just after the falling edge and samples 1 ns later, before the next rising edge. A write takes effect at the rising edge that closes its cycle, so a write's data is checked one cycle later, with the address held. Sleep and read-enable are combinational, so their effect is checked a fraction of a nanosecond after the input changes, with no clock edge in between.

// File: rtl/sburst_pkg.sv
// Shared definitions for the burst SRAM: burst order encoding and the
// low-address-bit generator. Assumes a 2-bit burst counter.
package sburst_pkg;

    typedef enum logic {
        ORD_XOR = 1'b0,
        ORD_INC = 1'b1
    } burst_order_e;

    localparam int unsigned BURST_W = 2;

    // Low address bits for a given start offset and burst count.
    function automatic logic [BURST_W-1:0] burst_low(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] cnt,
        input burst_order_e       ord
    );
        if (ord == ORD_INC) return start + cnt;
        return start ^ cnt;
    endfunction

endpackage

// File: rtl/sburst_seq.sv
// Address register, burst counter and active flag. It computes the address
// in effect this cycle from the registered state and the current strobes,
// so the array can be read in the same cycle. State is frozen while sleep
// is high. Assumes ADDR_W > 2.
module sburst_seq
    import sburst_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep_i,
    input  logic               sel_ok_i,
    input  logic               strobe_i,
    input  logic               adv_i,
    input  logic               lin_i,
    input  logic [ADDR_W-1:0]  addr_i,
    output logic [ADDR_W-1:0]  eff_addr_o,
    output logic               live_o,
    output logic [ADDR_W-1:0]  base_q,
    output logic [BURST_W-1:0] cnt_q,
    output logic               active_q
);

    logic               load;
    logic [ADDR_W-1:0]  base_n;
    logic [BURST_W-1:0] cnt_n;
    logic               active_n;
    burst_order_e       ord;

    // Next-state selection and the address used by this cycle.
    always_comb begin
        ord      = burst_order_e'(lin_i);
        load     = strobe_i & sel_ok_i;
        base_n   = load ? addr_i : base_q;
        cnt_n    = load ? '0 : (adv_i ? cnt_q + 1'b1 : cnt_q);
        active_n = strobe_i ? sel_ok_i : active_q;
        live_o   = active_n;
        eff_addr_o = {base_n[ADDR_W-1:BURST_W],
                      burst_low(base_n[BURST_W-1:0], cnt_n, ord)};
    end

    // Register update, held during sleep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (!sleep_i) begin
            base_q   <= base_n;
            cnt_q    <= cnt_n;
            active_q <= active_n;
        end
    end

endmodule

// File: rtl/sburst_array.sv
// Storage array split into byte lanes, one generate slice per lane.
// Combinational read and a per-lane synchronous write. The array has no
// reset, because contents are only defined once written.
module sburst_array #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 8
) (
    input  logic                      clk,
    input  logic [LANES-1:0]          we_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [LANES*LANE_W-1:0]   wdata_i,
    output logic [LANES*LANE_W-1:0]   rdata_o
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Lane write on the closing edge of a write cycle.
        always_ff @(posedge clk) begin
            if (we_i[g]) mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
        end

        // Flow-through lane read.
        assign rdata_o[g*LANE_W +: LANE_W] = mem[addr_i];
    end

endmodule

// File: rtl/sburst_sram.sv
// Top of the flow-through burst SRAM. It qualifies strobes with the chip
// selects, decodes global and byte writes into lane enables, and gates the
// read word with read-enable and sleep. Assumes lin_i is static.
module sburst_sram
    import sburst_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 8,
    parameter int unsigned DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              sel1_n_i,
    input  logic              sel2_i,
    input  logic              sel3_n_i,
    input  logic              ld_cpu_i,
    input  logic              ld_ctl_i,
    input  logic              adv_i,
    input  logic              lin_i,
    input  logic              bwe_i,
    input  logic [LANES-1:0]  lane_sel_i,
    input  logic              gwr_i,
    input  logic              rd_en_i,
    input  logic              sleep_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic               sel_ok;
    logic               strobe;
    logic               live;
    logic               wr_cyc;
    logic [LANES-1:0]   lane_we;
    logic [ADDR_W-1:0]  eff_addr;
    logic [DATA_W-1:0]  arr_rd;
    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q;
    logic               active_q;

    // Chip-select decode and strobe merge.
    always_comb begin
        sel_ok = ~sel1_n_i & sel2_i & ~sel3_n_i;
        strobe = ld_cpu_i | ld_ctl_i;
        wr_cyc = gwr_i | bwe_i;
    end

    sburst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_i    (sleep_i),
        .sel_ok_i   (sel_ok),
        .strobe_i   (strobe),
        .adv_i      (adv_i),
        .lin_i      (lin_i),
        .addr_i     (addr_i),
        .eff_addr_o (eff_addr),
        .live_o     (live),
        .base_q     (base_q),
        .cnt_q      (cnt_q),
        .active_q   (active_q)
    );

    // Lane enables: global write overrides the lane selects.
    always_comb begin
        lane_we = '0;
        if (!sleep_i && live) begin
            if (gwr_i)      lane_we = '1;
            else if (bwe_i) lane_we = lane_sel_i;
        end
    end

    sburst_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_arr (
        .clk     (clk),
        .we_i    (lane_we),
        .addr_i  (eff_addr),
        .wdata_i (wdata_i),
        .rdata_o (arr_rd)
    );

    // Output gating: read cycles with read-enable, not in sleep.
    always_comb begin
        rdata_o = (rd_en_i && !sleep_i && live && !wr_cyc) ? arr_rd : '0;
    end

endmodule

// File: rtl/sburst_sram_chk.sv
// Assertion checker for sburst_sram, attached by bind. It watches the top
// ports together with the sequencer state registers.
module sburst_sram_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_i,
    input logic              sel1_n_i,
    input logic              sel2_i,
    input logic              sel3_n_i,
    input logic              ld_cpu_i,
    input logic              ld_ctl_i,
    input logic              adv_i,
    input logic              bwe_i,
    input logic              gwr_i,
    input logic              rd_en_i,
    input logic              sleep_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic [ADDR_W-1:0] base_q,
    input logic [1:0]        cnt_q,
    input logic              active_q
);

    logic sel, stb;
    assign sel = ~sel1_n_i & sel2_i & ~sel3_n_i;
    assign stb = ld_cpu_i | ld_ctl_i;

    a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && sel && !sleep_i) |=> (base_q == $past(addr_i) && cnt_q == 2'd0));

    a_r2_desel_noload: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !sel && !sleep_i) |=> ($stable(base_q) && !active_q));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_q && !stb) |-> (rdata_o == '0));

    a_r3_adv_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!stb && adv_i && !sleep_i) |=> (cnt_q == $past(cnt_q) + 2'd1));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!stb && !adv_i && !sleep_i) |=> ($stable(base_q) && $stable(cnt_q)));

    a_r8_sleep_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> ($stable(base_q) && $stable(cnt_q) && $stable(active_q)));

    a_r8_sleep_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |-> (rdata_o == '0));

    a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en_i || gwr_i || bwe_i) |-> (rdata_o == '0));

endmodule

bind sburst_sram sburst_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_i   (addr_i),
    .sel1_n_i (sel1_n_i),
    .sel2_i   (sel2_i),
    .sel3_n_i (sel3_n_i),
    .ld_cpu_i (ld_cpu_i),
    .ld_ctl_i (ld_ctl_i),
    .adv_i    (adv_i),
    .bwe_i    (bwe_i),
    .gwr_i    (gwr_i),
    .rd_en_i  (rd_en_i),
    .sleep_i  (sleep_i),
    .rdata_o  (rdata_o),
    .base_q   (base_q),
    .cnt_q    (cnt_q),
    .active_q (active_q)
);

// File: tb/sburst_sram_tb.sv
`timescale 1ns/1ps
// Directed bench: inputs change just after the falling edge, and outputs
// are sampled 1 ns later, before the next rising edge.
module sburst_sram_tb;

    localparam int AW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] wdata_i = '0;
    logic          sel1_n_i = 1'b0, sel2_i = 1'b1, sel3_n_i = 1'b0;
    logic          ld_cpu_i = 1'b0, ld_ctl_i = 1'b0, adv_i = 1'b0;
    logic          lin_i = 1'b1, bwe_i = 1'b0, gwr_i = 1'b0;
    logic [3:0]    lane_sel_i = '0;
    logic          rd_en_i = 1'b1, sleep_i = 1'b0;
    logic [DW-1:0] rdata_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    sburst_sram u_dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
        .sel1_n_i(sel1_n_i), .sel2_i(sel2_i), .sel3_n_i(sel3_n_i),
        .ld_cpu_i(ld_cpu_i), .ld_ctl_i(ld_ctl_i), .adv_i(adv_i),
        .lin_i(lin_i), .bwe_i(bwe_i), .lane_sel_i(lane_sel_i),
        .gwr_i(gwr_i), .rd_en_i(rd_en_i), .sleep_i(sleep_i),
        .rdata_o(rdata_o)
    );

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return {a ^ 8'h3C, a, ~a, a + 8'h11};
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] exp);
        n_chk++;
        if (rdata_o !== exp) begin
            n_bad++;
            $display("FAIL %s: rdata=%h expected=%h", req, rdata_o, exp);
        end
    endtask

    task automatic idle();
        ld_cpu_i = 0; ld_ctl_i = 0; adv_i = 0;
        gwr_i = 0; bwe_i = 0; lane_sel_i = '0;
        sel1_n_i = 0; sel2_i = 1; sel3_n_i = 0;
    endtask

    // Sample within the current cycle, then move to the next falling edge.
    task automatic sample_next(input string req, input logic [DW-1:0] exp);
        #1 chk(req, exp);
        @(negedge clk);
    endtask

    task automatic t_reset();
        idle(); rd_en_i = 1;
        sample_next("R10", '0);
    endtask

    task automatic t_fill();
        for (int a = 0; a < 32; a++) begin
            idle(); addr_i = AW'(a); wdata_i = pat(AW'(a)); gwr_i = 1;
            ld_cpu_i = a[0]; ld_ctl_i = ~a[0];
            sample_next("R9", '0);
        end
        for (int a = 0; a < 32; a++) begin
            idle(); addr_i = AW'(a);
            ld_cpu_i = ~a[0]; ld_ctl_i = a[0];
            sample_next((a == 0) ? "R1" : "R6", pat(AW'(a)));
        end
    endtask

    task automatic t_burst(input logic lin, input logic [AW-1:0] start);
        logic [1:0] lo;
        lin_i = lin;
        idle(); addr_i = start; ld_cpu_i = 1;
        sample_next(lin ? "R3" : "R4", pat(start));
        for (int k = 1; k < 6; k++) begin
            idle(); adv_i = 1;
            lo = lin ? 2'(start[1:0] + 2'(k)) : 2'(start[1:0] ^ 2'(k));
            sample_next(lin ? "R3" : "R4", pat({start[AW-1:2], lo}));
        end
        lin_i = 1;
    endtask

    task automatic t_hold();
        idle(); addr_i = 8'd13; ld_ctl_i = 1;
        sample_next("R5", pat(8'd13));
        for (int k = 0; k < 3; k++) begin
            idle(); sample_next("R5", pat(8'd13));
        end
        idle(); adv_i = 1; sample_next("R5", pat(8'd14));
        idle(); sample_next("R5", pat(8'd14));
    endtask

    task automatic t_writes();
        idle(); addr_i = 8'd20; ld_cpu_i = 1; bwe_i = 1; lane_sel_i = 4'b0101;
        wdata_i = 32'hFFFF_FFFF;
        sample_next("R9", '0);
        idle(); sample_next("R7", (pat(8'd20) & 32'hFF00_FF00) | 32'h00FF_00FF);
        idle(); addr_i = 8'd21; ld_ctl_i = 1; gwr_i = 1; bwe_i = 1;
        lane_sel_i = 4'b0001; wdata_i = 32'h1234_5678;
        sample_next("R6", '0);
        idle(); sample_next("R6", 32'h1234_5678);
        idle(); addr_i = 8'd22; ld_cpu_i = 1; bwe_i = 1; lane_sel_i = 4'b0000;
        wdata_i = 32'h0;
        sample_next("R9", '0);
        idle(); sample_next("R7", pat(8'd22));
    endtask

    task automatic t_desel();
        idle(); sel1_n_i = 1; addr_i = 8'd30; ld_cpu_i = 1; gwr_i = 1;
        wdata_i = 32'hDEAD_BEEF;
        sample_next("R2", '0);
        idle(); sample_next("R2", '0);
        idle(); sel3_n_i = 1; adv_i = 1; sample_next("R2", '0);
        idle(); addr_i = 8'd30; ld_ctl_i = 1;
        sample_next("R2", pat(8'd30));
    endtask

    task automatic t_sleep();
        idle(); addr_i = 8'd5; ld_cpu_i = 1;
        sample_next("R8", pat(8'd5));
        idle();
        #1 chk("R8", pat(8'd5));
        sleep_i = 1;
        #0.5 chk("R8", '0);
        @(negedge clk);
        idle(); addr_i = 8'd5; ld_ctl_i = 1; gwr_i = 1; wdata_i = 32'h0BAD_0BAD;
        sample_next("R8", '0);
        idle(); addr_i = 8'd7; ld_cpu_i = 1; sample_next("R8", '0);
        idle(); sleep_i = 0;
        sample_next("R8", pat(8'd5));
        idle(); addr_i = 8'd7; ld_cpu_i = 1;
        sample_next("R8", pat(8'd7));
    endtask

    task automatic t_oe();
        idle(); addr_i = 8'd9; ld_cpu_i = 1; rd_en_i = 0;
        sample_next("R9", '0);
        idle();
        #1 chk("R9", '0);
        rd_en_i = 1;
        #0.5 chk("R9", pat(8'd9));
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_burst(1'b1, 8'd6);
        t_burst(1'b0, 8'd9);
        t_burst(1'b0, 8'd18);
        t_hold();
        t_writes();
        t_desel();
        t_sleep();
        t_oe();
        done = 1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            summary();
        end
    end

endmodule